// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a watchdog timer with a small register file of 32-bit words. A free-running counter advances once per input clock while it is enabled. A window of that counter, picked by a power-of-two scale, is compared with a 16-bit threshold. When the threshold is reached, the block sets a sticky pending flag and raises an interrupt. Depending on its configuration, it can also zero the counter or issue a one-cycle request for a system reset.

All writes are guarded by a lock. A write to any register other than the key register takes effect only if the write just before it put the unlock word into the key register. Each unlock covers exactly one write. Software keeps the watchdog alive by writing the feed word to the feed register, and that write also needs a fresh unlock. Reads are combinational on a separate read address and need no unlock.

Register word offsets on the address input: 0 = configuration, 1 = counter, 2 = feed, 3 = key, 4 = threshold. Configuration fields: bits [2:0] hold the scale s, bit 8 enables the reset request, bit 9 enables auto-zero, bit 12 selects always-run, bit 13 selects run-while-awake, bit 28 is the pending flag, and bit 30 (read only) shows the unlock state.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, configuration reads 0, counter reads 0, threshold reads 0x0000FFFF, and irq_o and sys_rst_o are low.
- R2: A write to offset 0, 1, 2 or 4 is applied only if the previous write was 0x0051F15E to offset 3. Each unlock is used up by the next write, whatever its target. A key write with any other value relocks. Configuration bit 30 reads 1 while unlocked.
- R3: The counter increments by one each clock when configuration bit 12 is set, or when bit 13 is set and core_awake_i is high. With both bits clear, the counter holds its value.
- R4: An applied write of 0x0D09F00D to offset 2 zeroes the counter. An applied feed write with any other value leaves the counter unchanged but still uses up the unlock.
- R5: The compared value is counter[s+15:s], where s is configuration bits [2:0]. A match exists while that value is greater than or equal to threshold bits [15:0]. The pending flag is set on the clock edge after a match is present.
- R6: The pending flag drives irq_o and stays set until an applied configuration write with bit 28 at 0. That write clears it only if no match is present.
- R7: With configuration bit 9 set, the clock edge that sees a match loads the counter with zero.
- R8: With configuration bit 8 set, sys_rst_o is high for exactly one cycle, on the clock edge after a match first appears.
- R9: Because the comparison runs continuously, writing a threshold of 0 sets the pending flag on the next clock edge.
- R10: An applied write to offset 1 loads the counter with bits [30:0] of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | 3 | Write word offset |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read word offset |
| rd_data_o | output | 32 | Read data (combinational) |
| core_awake_i | input | 1 | Core awake indication for run-while-awake mode |
| irq_o | output | 1 | Pending interrupt flag |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
The bench checks that an unlock covers exactly one write. If the lock stayed open after one write, the second unguarded configuration write would land. A bad feed word must leave the counter alone but still relock, which catches a design that treats any feed value as valid. The bench measures the delay to irq_o with scale 2 and threshold 5, and the delay to sys_rst_o, to the exact cycle. A wrong window shift or an extra register stage shows up as a different count. The bench also confirms three more points: the pending flag cannot be cleared while a match is still present, auto-zero keeps the counter at or below the threshold, and a zero threshold raises the interrupt one cycle after the write.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CFG   = 3'd0,
        SEL_COUNT = 3'd1,
        SEL_FEED  = 3'd2,
        SEL_KEY   = 3'd3,
        SEL_CMP   = 3'd4
    } reg_sel_e;

    localparam logic [DATA_W-1:0] UNLOCK_WORD = 32'h0051_F15E;
    localparam logic [DATA_W-1:0] FEED_WORD   = 32'h0D09_F00D;

    // configuration bit positions
    localparam int unsigned CB_SCALE_LSB = 0;
    localparam int unsigned CB_RST_EN    = 8;
    localparam int unsigned CB_AUTO_ZERO = 9;
    localparam int unsigned CB_RUN_ALL   = 12;
    localparam int unsigned CB_RUN_AWAKE = 13;
    localparam int unsigned CB_PENDING   = 28;
    localparam int unsigned CB_UNLOCKED  = 30;

endpackage

// File: rtl/keyed_wdt_lock.sv
module keyed_wdt_lock (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_en_i,
    input  logic key_sel_i,
    input  logic key_ok_i,
    output logic unlocked_o,
    output logic accept_o
);

    logic open_d, open_q;

    always_comb begin
        open_d = open_q;
        if (wr_en_i) begin
            if (key_sel_i) open_d = key_ok_i;
            else           open_d = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) open_q <= 1'b0;
        else         open_q <= open_d;
    end

    assign unlocked_o = open_q;
    assign accept_o   = wr_en_i && !key_sel_i && open_q;

endmodule

// File: rtl/keyed_wdt_cnt.sv
module keyed_wdt_cnt #(
    parameter int unsigned CNT_W   = 31,
    parameter int unsigned CMP_W   = 16,
    parameter int unsigned SCALE_W = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic               clear_i,
    input  logic               load_i,
    input  logic [CNT_W-1:0]   load_val_i,
    input  logic               auto_zero_i,
    input  logic [SCALE_W-1:0] scale_i,
    input  logic [CMP_W-1:0]   thresh_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               match_o
);

    localparam int unsigned N_SCALE = 2 ** SCALE_W;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CMP_W-1:0] window [N_SCALE];
    logic [CMP_W-1:0] scaled;

    for (genvar s = 0; s < N_SCALE; s++) begin : g_win
        assign window[s] = cnt_q[s+CMP_W-1:s];
    end

    assign scaled  = window[scale_i];
    assign match_o = (scaled >= thresh_i);

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)                     cnt_d = '0;
        else if (load_i)                 cnt_d = load_val_i;
        else if (match_o && auto_zero_i) cnt_d = '0;
        else if (run_i)                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import keyed_wdt_pkg::*;
#(
    parameter int unsigned CNT_W   = 31,
    parameter int unsigned CMP_W   = 16,
    parameter int unsigned SCALE_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              core_awake_i,
    output logic              irq_o,
    output logic              sys_rst_o
);

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic               rst_en;
        logic               auto_zero;
        logic               run_all;
        logic               run_awake;
        logic               pending;
        logic [CMP_W-1:0]   thresh;
        logic               match_seen;
        logic               rst_pulse;
    } state_t;

    state_t st_d, st_q;

    reg_sel_e         wsel;
    logic             unlocked, accept;
    logic             run, feed_hit, cnt_load, match;
    logic [CNT_W-1:0] cnt;

    assign wsel = reg_sel_e'(wr_addr_i);

    keyed_wdt_lock u_lock (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .key_sel_i  (wsel == SEL_KEY),
        .key_ok_i   (wr_data_i == UNLOCK_WORD),
        .unlocked_o (unlocked),
        .accept_o   (accept)
    );

    assign run      = st_q.run_all || (st_q.run_awake && core_awake_i);
    assign feed_hit = accept && (wsel == SEL_FEED) && (wr_data_i == FEED_WORD);
    assign cnt_load = accept && (wsel == SEL_COUNT);

    keyed_wdt_cnt #(
        .CNT_W   (CNT_W),
        .CMP_W   (CMP_W),
        .SCALE_W (SCALE_W)
    ) u_cnt (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (run),
        .clear_i     (feed_hit),
        .load_i      (cnt_load),
        .load_val_i  (wr_data_i[CNT_W-1:0]),
        .auto_zero_i (st_q.auto_zero),
        .scale_i     (st_q.scale),
        .thresh_i    (st_q.thresh),
        .cnt_o       (cnt),
        .match_o     (match)
    );

    always_comb begin
        st_d = st_q;
        if (accept && wsel == SEL_CFG) begin
            st_d.scale     = wr_data_i[CB_SCALE_LSB +: SCALE_W];
            st_d.rst_en    = wr_data_i[CB_RST_EN];
            st_d.auto_zero = wr_data_i[CB_AUTO_ZERO];
            st_d.run_all   = wr_data_i[CB_RUN_ALL];
            st_d.run_awake = wr_data_i[CB_RUN_AWAKE];
            st_d.pending   = wr_data_i[CB_PENDING];
        end
        if (accept && wsel == SEL_CMP) begin
            st_d.thresh = wr_data_i[CMP_W-1:0];
        end
        st_d.pending    = st_d.pending || match;
        st_d.match_seen = match;
        st_d.rst_pulse  = match && !st_q.match_seen && st_q.rst_en;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q        <= '0;
            st_q.thresh <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        unique case (reg_sel_e'(rd_addr_i))
            SEL_CFG: begin
                rd_data_o[CB_SCALE_LSB +: SCALE_W] = st_q.scale;
                rd_data_o[CB_RST_EN]    = st_q.rst_en;
                rd_data_o[CB_AUTO_ZERO] = st_q.auto_zero;
                rd_data_o[CB_RUN_ALL]   = st_q.run_all;
                rd_data_o[CB_RUN_AWAKE] = st_q.run_awake;
                rd_data_o[CB_PENDING]   = st_q.pending;
                rd_data_o[CB_UNLOCKED]  = unlocked;
            end
            SEL_COUNT: rd_data_o[CNT_W-1:0] = cnt;
            SEL_CMP:   rd_data_o[CMP_W-1:0] = st_q.thresh;
            default:   rd_data_o = '0;
        endcase
    end

    assign irq_o     = st_q.pending;
    assign sys_rst_o = st_q.rst_pulse;

endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
    import keyed_wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 31
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic              irq_o,
    input logic              sys_rst_o,
    input logic              unlocked,
    input logic              run,
    input logic              match,
    input logic [CNT_W-1:0]  cnt
);

    // R2
    unlock_spent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i != SEL_KEY) |=> !unlocked);

    // R3
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run && !wr_en_i && !match) |=> $stable(cnt));

    // R5
    match_sets_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match |=> irq_o);

    // R6
    pending_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !(wr_en_i && wr_addr_i == SEL_CFG)) |=> irq_o);

    // R8
    rst_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_rst_o |=> !sys_rst_o);

    // R8
    rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_rst_o |-> $past(match));

endmodule

bind keyed_wdt keyed_wdt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .irq_o     (irq_o),
    .sys_rst_o (sys_rst_o),
    .unlocked  (unlocked),
    .run       (run),
    .match     (match),
    .cnt       (cnt)
);

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;

    localparam logic [2:0] A_CFG = 3'd0, A_CNT = 3'd1, A_FEED = 3'd2, A_KEY = 3'd3, A_CMP = 3'd4;
    localparam logic [31:0] KEYW = 32'h0051_F15E;
    localparam logic [31:0] FOOD = 32'h0D09_F00D;
    localparam logic [31:0] RUN_ALL = 32'h1000, RUN_AWK = 32'h2000, AZERO = 32'h200, RSTEN = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        awake = 1'b0;
    logic        irq, sys_rst;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    keyed_wdt dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .core_awake_i (awake),
        .irq_o        (irq),
        .sys_rst_o    (sys_rst)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic uwr(input logic [2:0] a, input logic [31:0] d);
        wr(A_KEY, KEYW);
        wr(a, d);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CFG, v); chk("R1 cfg", v, 32'h0);
        rd(A_CNT, v); chk("R1 count", v, 32'h0);
        rd(A_CMP, v); chk("R1 thresh", v, 32'hFFFF);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 sys_rst", {31'b0, sys_rst}, 32'h0);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        wr(A_CFG, RUN_ALL);
        rd(A_CFG, v); chk("R2 write without key ignored", v, 32'h0);
        wr(A_KEY, KEYW);
        rd(A_CFG, v); chk("R2 unlock bit set", v[30], 1'b1);
        wr(A_KEY, 32'h1234);
        rd(A_CFG, v); chk("R2 wrong key relocks", v[30], 1'b0);
        uwr(A_CFG, 32'h5);
        rd(A_CFG, v); chk("R2 unlocked write applied", v, 32'h5);
        wr(A_CFG, 32'h3);
        rd(A_CFG, v); chk("R2 second write refused", v, 32'h5);
        uwr(A_CFG, 32'h0);
    endtask

    task automatic t_load_stop();
        logic [31:0] v;
        uwr(A_CNT, 32'd100);
        rd(A_CNT, v); chk("R10 count load", v, 32'd100);
        repeat (5) @(negedge clk);
        rd(A_CNT, v); chk("R3 stopped holds", v, 32'd100);
    endtask

    task automatic t_run();
        logic [31:0] a, b;
        uwr(A_CFG, RUN_ALL);
        rd(A_CNT, a); repeat (7) @(negedge clk); rd(A_CNT, b);
        chk("R3 always-run +7", b - a, 32'd7);
        uwr(A_CFG, RUN_AWK);
        rd(A_CNT, a); repeat (5) @(negedge clk); rd(A_CNT, b);
        chk("R3 asleep holds", b - a, 32'd0);
        awake = 1'b1;
        rd(A_CNT, a); repeat (5) @(negedge clk); rd(A_CNT, b);
        chk("R3 awake +5", b - a, 32'd5);
        uwr(A_CFG, 32'h0);
        awake = 1'b0;
    endtask

    task automatic t_feed();
        logic [31:0] v;
        uwr(A_CNT, 32'd50);
        uwr(A_FEED, 32'h1234_5678);
        rd(A_CNT, v); chk("R4 bad feed ignored", v, 32'd50);
        rd(A_CFG, v); chk("R4 bad feed relocks", v[30], 1'b0);
        uwr(A_FEED, FOOD);
        rd(A_CNT, v); chk("R4 feed zeroes", v, 32'd0);
    endtask

    task automatic t_scale();
        int n = 0;
        uwr(A_CMP, 32'd5);
        uwr(A_CFG, RUN_ALL | 32'h2);
        while (!irq && n < 200) begin @(negedge clk); n++; end
        chk("R5 scale 2 thresh 5 latency", n, 32'd21);
        chk("R8 no request without enable", {31'b0, sys_rst}, 32'h0);
    endtask

    task automatic t_clear();
        uwr(A_CFG, 32'h0);
        chk("R6 clear refused during match", {31'b0, irq}, 32'h1);
        uwr(A_FEED, FOOD);
        uwr(A_CFG, 32'h0);
        chk("R6 clear applied", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_autozero();
        logic [31:0] v;
        logic [31:0] mx = 0;
        int zeros = 0;
        uwr(A_CMP, 32'd4);
        uwr(A_CFG, RUN_ALL | AZERO);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            rd(A_CNT, v);
            if (v > mx) mx = v;
            if (v == 0) zeros++;
        end
        chk("R7 count bounded by thresh", mx, 32'd4);
        chk("R7 wrapped to zero", {31'b0, zeros > 1}, 32'h1);
        chk("R6 pending sticky after wrap", {31'b0, irq}, 32'h1);
        uwr(A_CFG, 32'h0);
        uwr(A_FEED, FOOD);
        uwr(A_CFG, 32'h0);
    endtask

    task automatic t_zero_thresh();
        chk("R9 idle before", {31'b0, irq}, 32'h0);
        uwr(A_CMP, 32'd0);
        chk("R9 not yet set", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R9 set next edge", {31'b0, irq}, 32'h1);
        uwr(A_CMP, 32'd6);
        uwr(A_CFG, 32'h0);
        chk("R6 cleared", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_rst_pulse();
        int n = 0;
        int hi = 0;
        uwr(A_CFG, RUN_ALL | RSTEN);
        while (!sys_rst && n < 200) begin @(negedge clk); n++; end
        chk("R8 request latency", n, 32'd7);
        @(negedge clk);
        chk("R8 request one cycle", {31'b0, sys_rst}, 32'h0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sys_rst) hi++;
        end
        chk("R8 no repeat while match held", hi, 32'd0);
        chk("R5 pending set", {31'b0, irq}, 32'h1);
    endtask

    initial begin : watchdog
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lock();
        t_load_stop();
        t_run();
        t_feed();
        t_scale();
        t_clear();
        t_autozero();
        t_zero_thresh();
        t_rst_pulse();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule